// File: doc/BRIEF.md
# Receive Frame Queue with DMA Readout Window

This block holds received frames in a small queue and shows the oldest one as four 32-bit words in a fixed read window. The words sit at byte offsets 0x0, 0x4, 0x8 and 0xC from a window base of 0x80. While the queue holds a frame, a frames-available flag is high. When DMA mode is on, a DMA request rises in the same cycle as that flag. Reading the last word of the window at 0x8C ends the readout of that frame. The read retires the head frame and drops both the flag and the request. If more frames wait, both signals come back one cycle later, so every frame gets its own request.

DMA mode is on only when the queue-enable input and the DMA-enable input are both high. In that mode, reads from the CPU side of the window are refused: they return zero and change nothing. A clear command empties the queue at any time, and software issues it before leaving DMA mode. A filter-hit index travels with each frame and is shown for the head frame while the flag is high.

Top module: `rxq_dma_port`

## Requirements
- R1: After reset, `frames_avail`, `dma_req` and `overflow` are 0, `hit_index` is 0, and any window read returns 0.
- R2: A frame pushed into an empty queue raises `frames_avail` on the clock edge that takes it. Word k of `push_data` (bits 32k+31..32k) is then read at address 0x80+4k, and `hit_index` equals the pushed hit value.
- R3: `dma_req` is high exactly when `frames_avail`, `fifo_en` and `dma_en` are all high. It rises in the same cycle as the flag.
- R4: An accepted read of 0x8C while `frames_avail` is high retires the head frame, and the next cycle shows `frames_avail` and `dma_req` low. If frames remain, both are high again one cycle after that, and the window then shows the next frame in push order.
- R5: Reads of 0x80, 0x84 and 0x88 leave the flag, the head frame and the queue contents unchanged.
- R6: A read of 0x8C while `frames_avail` is low returns 0 and changes nothing.
- R7: In DMA mode, a read with `rd_dma`=0 returns 0 and never retires a frame, while reads with `rd_dma`=1 work normally.
- R8: The queue holds 6 frames. A push into a full queue, with no retire in the same cycle, is dropped and sets `overflow`, which stays set until a clear.
- R9: `clear_cmd` empties the queue and clears `overflow` on its edge. It wins over a push in the same cycle, and that push is dropped.
- R10: `hit_index` is 0 whenever `frames_avail` is low.
- R11: A push and a retire in the same cycle on a full queue both take effect. There is no overflow, and the new frame is queued last.
- R12: While `fifo_en` is low, pushes are dropped without setting `overflow`, and `frames_avail` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queue enable |
| dma_en | input | 1 | DMA enable; DMA mode when both enables are high |
| clear_cmd | input | 1 | Empty the queue and clear the overflow bit |
| push_valid | input | 1 | Frame push strobe |
| push_data | input | 128 | Four frame words, word 0 in bits 31..0 |
| push_hit | input | 9 | Filter-hit index of the pushed frame |
| rd_en | input | 1 | Read strobe |
| rd_dma | input | 1 | 1 when the DMA side is reading, 0 when the CPU is |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data in the same cycle; 0 if the read is refused or falls outside the window |
| frames_avail | output | 1 | At least one frame is ready to read |
| dma_req | output | 1 | DMA request |
| hit_index | output | 9 | Filter-hit index of the head frame |
| overflow | output | 1 | Sticky: a push was dropped because the queue was full |

## Verification
A push can arrive in the same cycle as the 0x8C read that retires the head frame. This matters most when the queue is full, where the retire must free the slot the push needs. The bench fills all six slots, then asserts `push_valid` and the 0x8C read together. It checks that `overflow` stays clear, that the flag drops for one cycle, and that the six frames then drain in push order with the new frame last. A clear and a push are also driven in the same cycle, and the bench checks that the queue stays empty.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
   localparam int unsigned WIN_WORDS = 4;
   localparam logic [1:0]  LAST_SLOT = 2'd3;

   function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
      return (p == depth - 1) ? 0 : p + 1;
   endfunction
endpackage

// File: rtl/rxq_frame_store.sv
`timescale 1ns/1ps
module rxq_frame_store #(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HIT_W  = 9,
   localparam int unsigned FRAME_W = rxq_pkg::WIN_WORDS * DATA_W,
   localparam int unsigned SLOT_W  = FRAME_W + HIT_W,
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               push,
   input  logic               pop,
   input  logic [FRAME_W-1:0] push_frame,
   input  logic [HIT_W-1:0]   push_hit,
   output logic [FRAME_W-1:0] head_frame,
   output logic [HIT_W-1:0]   head_hit,
   output logic               nonempty_next,
   output logic               overflow
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [SLOT_W-1:0] slot_q [DEPTH];
   logic empty, full, pop_ok, push_ok, drop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty && !clear;
   assign push_ok = push && !clear && (!full || pop_ok);
   assign drop    = push && !clear && full && !pop_ok;

   always_comb begin
      if (clear) cnt_d = '0;
      else       cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
   end
   assign nonempty_next = (cnt_d != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         overflow <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (clear) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
         end else begin
            if (push_ok) wr_ptr <= PTR_W'(rxq_pkg::wrap_inc(int'(wr_ptr), DEPTH));
            if (pop_ok)  rd_ptr <= PTR_W'(rxq_pkg::wrap_inc(int'(rd_ptr), DEPTH));
            if (drop)    overflow <= 1'b1;
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 slot_q[i] <= '0;
         else if (push_ok && wr_ptr == PTR_W'(i))    slot_q[i] <= {push_hit, push_frame};
      end
   end

   assign head_frame = slot_q[rd_ptr][FRAME_W-1:0];
   assign head_hit   = slot_q[rd_ptr][SLOT_W-1:FRAME_W];
endmodule

// File: rtl/rxq_window.sv
`timescale 1ns/1ps
module rxq_window #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter logic [ADDR_W-1:0] BASE   = 8'h80,
   parameter bit          STRICT_ALIGN = 1'b1,
   localparam int unsigned FRAME_W = rxq_pkg::WIN_WORDS * DATA_W
) (
   input  logic               rd_en,
   input  logic               rd_dma,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic               dma_mode,
   input  logic               avail,
   input  logic [FRAME_W-1:0] head_frame,
   output logic [DATA_W-1:0]  rd_data,
   output logic               pop
);
   if (BASE[3:0] != 4'h0) begin : g_bad_base
      $error("rxq_window: BASE must be 16-byte aligned");
   end

   logic [DATA_W-1:0] words [rxq_pkg::WIN_WORDS];
   for (genvar k = 0; k < rxq_pkg::WIN_WORDS; k++) begin : g_word
      assign words[k] = head_frame[k*DATA_W +: DATA_W];
   end

   logic in_win, aligned, granted;
   logic [1:0] slot;

   assign in_win = (rd_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
   assign slot   = rd_addr[3:2];

   if (STRICT_ALIGN) begin : g_strict
      assign aligned = (rd_addr[1:0] == 2'b00);
   end else begin : g_loose
      assign aligned = 1'b1;
   end

   assign granted = rd_en && in_win && aligned && avail && !(dma_mode && !rd_dma);
   assign rd_data = granted ? words[slot] : '0;
   assign pop     = granted && (slot == rxq_pkg::LAST_SLOT);
endmodule

// File: rtl/rxq_flag.sv
`timescale 1ns/1ps
module rxq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_en,
   input  logic dma_mode,
   input  logic clear,
   input  logic pop,
   input  logic nonempty_next,
   output logic frames_avail,
   output logic dma_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frames_avail <= 1'b0;
      else        frames_avail <= fifo_en && !clear && !pop && nonempty_next;
   end
   assign dma_req = frames_avail && dma_mode;
endmodule

// File: rtl/rxq_dma_port.sv
`timescale 1ns/1ps
module rxq_dma_port #(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HIT_W  = 9,
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE = 8'h80,
   parameter bit          STRICT_ALIGN = 1'b1,
   localparam int unsigned FRAME_W = rxq_pkg::WIN_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_en,
   input  logic               dma_en,
   input  logic               clear_cmd,
   input  logic               push_valid,
   input  logic [FRAME_W-1:0] push_data,
   input  logic [HIT_W-1:0]   push_hit,
   input  logic               rd_en,
   input  logic               rd_dma,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic               frames_avail,
   output logic               dma_req,
   output logic [HIT_W-1:0]   hit_index,
   output logic               overflow
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_dma_port: DEPTH must be at least 2");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("rxq_dma_port: ADDR_W too small for the window");
   end

   logic               dma_mode, pop, nonempty_next;
   logic [FRAME_W-1:0] head_frame;
   logic [HIT_W-1:0]   head_hit;

   assign dma_mode = fifo_en && dma_en;

   rxq_frame_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .HIT_W(HIT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear_cmd),
      .push(push_valid && fifo_en), .pop(pop),
      .push_frame(push_data), .push_hit(push_hit),
      .head_frame(head_frame), .head_hit(head_hit),
      .nonempty_next(nonempty_next), .overflow(overflow)
   );

   rxq_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(WIN_BASE),
                .STRICT_ALIGN(STRICT_ALIGN)) u_window (
      .rd_en(rd_en), .rd_dma(rd_dma), .rd_addr(rd_addr),
      .dma_mode(dma_mode), .avail(frames_avail), .head_frame(head_frame),
      .rd_data(rd_data), .pop(pop)
   );

   rxq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
      .clear(clear_cmd), .pop(pop), .nonempty_next(nonempty_next),
      .frames_avail(frames_avail), .dma_req(dma_req)
   );

   assign hit_index = frames_avail ? head_hit : '0;
endmodule

// File: rtl/rxq_dma_port_chk.sv
`timescale 1ns/1ps
module rxq_dma_port_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HIT_W  = 9,
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE = 8'h80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_en,
   input logic              dma_en,
   input logic              clear_cmd,
   input logic              rd_en,
   input logic              rd_dma,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              frames_avail,
   input logic              dma_req,
   input logic [HIT_W-1:0]  hit_index,
   input logic              overflow
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = WIN_BASE + ADDR_W'(12);
   logic cpu_blocked, last_read, early_read;
   assign cpu_blocked = fifo_en && dma_en && !rd_dma;
   assign last_read   = rd_en && rd_addr == LAST_ADDR && !cpu_blocked;
   assign early_read  = rd_en && (rd_addr == WIN_BASE || rd_addr == WIN_BASE + ADDR_W'(4)
                                  || rd_addr == WIN_BASE + ADDR_W'(8));

   assert_req_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> frames_avail && fifo_en && dma_en);
   assert_pop_drops_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (last_read && frames_avail) |=> !frames_avail && !dma_req);
   assert_early_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (early_read && frames_avail && fifo_en && !clear_cmd) |=> frames_avail);
   assert_cpu_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && cpu_blocked) |-> rd_data == '0);
   assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clear_cmd) |=> overflow);
   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear_cmd |=> !frames_avail && !overflow);
   assert_hit_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !frames_avail |-> hit_index == '0);
   assert_disabled_no_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> !frames_avail);
endmodule

bind rxq_dma_port rxq_dma_port_chk #(
   .DATA_W(DATA_W), .HIT_W(HIT_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
   .clear_cmd(clear_cmd), .rd_en(rd_en), .rd_dma(rd_dma), .rd_addr(rd_addr),
   .rd_data(rd_data), .frames_avail(frames_avail), .dma_req(dma_req),
   .hit_index(hit_index), .overflow(overflow)
);

// File: tb/test_rxq_dma_port.sv
`timescale 1ns/1ps
module test_rxq_dma_port;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fifo_en = 1'b0, dma_en = 1'b0, clear_cmd = 1'b0;
   logic         push_valid = 1'b0;
   logic [127:0] push_data = '0;
   logic [8:0]   push_hit = '0;
   logic         rd_en = 1'b0, rd_dma = 1'b0;
   logic [7:0]   rd_addr = '0;
   logic [31:0]  rd_data;
   logic         frames_avail, dma_req, overflow;
   logic [8:0]   hit_index;
   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rxq_dma_port i_rxq_dma_port (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
      .clear_cmd(clear_cmd), .push_valid(push_valid), .push_data(push_data),
      .push_hit(push_hit), .rd_en(rd_en), .rd_dma(rd_dma), .rd_addr(rd_addr),
      .rd_data(rd_data), .frames_avail(frames_avail), .dma_req(dma_req),
      .hit_index(hit_index), .overflow(overflow)
   );

   localparam logic [40:0] VEC [4] = '{
      {9'h0A5, 32'h1234_5670}, {9'h1FF, 32'h0BAD_F00D},
      {9'h000, 32'h7777_0001}, {9'h13C, 32'hC0DE_4400}
   };

   function automatic logic [31:0] fw(input logic [31:0] seed, input int k);
      return seed ^ (32'(k) << 28) ^ 32'(k);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push_frame(input logic [31:0] seed, input logic [8:0] hit);
      @(negedge clk);
      push_valid = 1'b1; push_hit = hit;
      for (int k = 0; k < 4; k++) push_data[32*k +: 32] = fw(seed, k);
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input bit dma, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; rd_dma = dma;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); clear_cmd = 1'b1;
      @(negedge clk); clear_cmd = 1'b0;
   endtask

   task automatic read_frame(input logic [31:0] seed, input logic [8:0] hit,
                             input bit dma, input bit more);
      logic [31:0] d;
      chk("R2 hit_index", 32'(hit_index), 32'(hit));
      for (int k = 0; k < 3; k++) begin
         rd(8'h80 + 8'(4*k), dma, d);
         chk("R2 word", d, fw(seed, k));
      end
      chk("R5 flag kept", 32'(frames_avail), 1);
      rd(8'h8C, dma, d);
      chk("R2 last word", d, fw(seed, 3));
      chk("R4 flag low after pop", 32'(frames_avail), 0);
      chk("R4 req low after pop", 32'(dma_req), 0);
      chk("R10 hit zero", 32'(hit_index), 0);
      @(negedge clk);
      chk("R4 flag back", 32'(frames_avail), 32'(more));
      chk("R4 req back", 32'(dma_req), 32'(more && dma_en));
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 flag", 32'(frames_avail), 0);
      chk("R1 req", 32'(dma_req), 0);
      chk("R1 overflow", 32'(overflow), 0);
      chk("R1 hit", 32'(hit_index), 0);
      rd(8'h80, 1'b0, d);
      chk("R1 read zero", d, 0);

      // R12 disabled queue ignores pushes
      push_frame(32'hDEAD_0000, 9'h011);
      chk("R12 flag low", 32'(frames_avail), 0);
      chk("R12 no overflow", 32'(overflow), 0);
      fifo_en = 1'b1;
      @(negedge clk);
      chk("R12 nothing stored", 32'(frames_avail), 0);

      // vector table: push all, then read back in order (CPU mode)
      foreach (VEC[i]) begin
         push_frame(VEC[i][31:0], VEC[i][40:32]);
         chk("R2 flag after push", 32'(frames_avail), 1);
         chk("R3 no req outside DMA mode", 32'(dma_req), 0);
      end
      foreach (VEC[i]) read_frame(VEC[i][31:0], VEC[i][40:32], 1'b0, i != 3);

      // R6 empty last-word read
      rd(8'h8C, 1'b0, d);
      chk("R6 empty read zero", d, 0);
      chk("R6 flag stays low", 32'(frames_avail), 0);
      push_frame(32'h5151_0000, 9'h051);
      read_frame(32'h5151_0000, 9'h051, 1'b0, 1'b0);

      // DMA mode: R3 and R7
      dma_en = 1'b1;
      push_frame(32'hA0A0_0000, 9'h0AA);
      chk("R3 req with flag", 32'(dma_req), 1);
      rd(8'h8C, 1'b0, d);
      chk("R7 cpu read zero", d, 0);
      chk("R7 cpu no pop", 32'(frames_avail), 1);
      fifo_en = 1'b0;
      #1 chk("R3 req needs fifo_en", 32'(dma_req), 0);
      fifo_en = 1'b1;
      @(negedge clk);
      chk("R3 req returns", 32'(dma_req), 1);
      read_frame(32'hA0A0_0000, 9'h0AA, 1'b1, 1'b0);
      do_clear();
      dma_en = 1'b0;

      // R8 overflow
      for (int i = 0; i < 7; i++) push_frame(32'h1000_0000 + 32'(i), 9'(i));
      chk("R8 overflow set", 32'(overflow), 1);
      for (int i = 0; i < 6; i++) read_frame(32'h1000_0000 + 32'(i), 9'(i), 1'b0, i != 5);
      chk("R8 overflow sticky", 32'(overflow), 1);
      do_clear();
      chk("R9 overflow cleared", 32'(overflow), 0);

      // R9 clear with content, clear beating push
      for (int i = 0; i < 3; i++) push_frame(32'h3000_0000 + 32'(i), 9'(i));
      do_clear();
      chk("R9 flag low", 32'(frames_avail), 0);
      @(negedge clk);
      clear_cmd = 1'b1; push_valid = 1'b1; push_data = '1;
      @(negedge clk);
      clear_cmd = 1'b0; push_valid = 1'b0;
      @(negedge clk);
      chk("R9 push dropped", 32'(frames_avail), 0);
      rd(8'h8C, 1'b0, d);
      chk("R9 empty after clear", d, 0);

      // R11 push and retire together on a full queue
      for (int i = 0; i < 6; i++) push_frame(32'h2000_0000 + 32'(i), 9'(16 + i));
      @(negedge clk);
      push_valid = 1'b1; push_hit = 9'd22;
      for (int k = 0; k < 4; k++) push_data[32*k +: 32] = fw(32'h2000_0006, k);
      rd_en = 1'b1; rd_addr = 8'h8C; rd_dma = 1'b0;
      #1 chk("R11 popped word", rd_data, fw(32'h2000_0000, 3));
      @(negedge clk);
      push_valid = 1'b0; rd_en = 1'b0;
      chk("R11 no overflow", 32'(overflow), 0);
      chk("R11 flag gap", 32'(frames_avail), 0);
      @(negedge clk);
      for (int i = 1; i < 7; i++) read_frame(32'h2000_0000 + 32'(i), 9'(16 + i), 1'b0, i != 6);

      done = 1;
      finish_run();
   end
endmodule